// File: doc/BRIEF.md
# Dual-Processor Fault Handoff Controller

This block decides which of two processors may drive a shared memory bus in a system with demand-paged memory. The executor processor runs ordinary code. A fault from the address-translation unit freezes the executor. The executor is halted and cut off from the bus, and its internal state is left untouched. A second processor, the fixer, is then released and runs the fault handler. The fixer ends handling by writing to one decoded control address. The executor is then released and finishes the interrupted instruction, and the fixer goes back into halt.

Every change of bus owner passes through one dead cycle in which neither processor has its bus drivers enabled. The address of the faulting access is latched so the fixer can read it. A fault raised when the executor does not own the bus sets a sticky error flag and is otherwise ignored. A phase output reports where the handoff stands.

Top module: `fault_handoff_ctrl`

## Requirements
- R1: While reset is high and after it is released, phase is 0 (executor running), the executor is running with its bus enabled, the fixer is halted with its bus disabled, the latched address is zero and the error flag is clear.
- R2: A fault sampled in phase 0 moves the block to phase 1 (handing off) at the next clock edge. In phase 1 both processors are halted and neither bus enable is high.
- R3: One cycle after phase 1 the block enters phase 2 (fixer running). In phase 2 the fixer is released with its bus enabled, and the executor stays halted with its bus disabled.
- R4: A completion is a fixer write strobe whose address equals the parameter CTRL_ADDR. A completion in phase 2 moves the block to phase 3 (handing back), in which both processors are halted and neither bus enable is high. At the next edge the block returns to phase 0, where the executor is released and regains the bus.
- R5: The two bus enables are never high together. Each enable rises only after a cycle in which the other was low.
- R6: The fault address is captured at the edge where a fault is accepted in phase 0. It then holds unchanged until the next accepted fault.
- R7: A fault sampled in phases 1, 2 or 3 sets the error flag. It changes neither the phase nor the latched address. The flag stays set until reset.
- R8: A fixer write to any other address, or a completion strobe outside phase 2, has no effect on phase, bus ownership or the latched address.
- R9: If a fault and a completion arrive in the same phase-2 cycle, the completion is honoured (phase 3 follows) and the error flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_fault | input | 1 | Fault from the address-translation unit |
| fault_addr_in | input | ADDR_W | Address of the access being translated |
| fix_wr_en | input | 1 | Fixer bus write strobe |
| fix_wr_addr | input | ADDR_W | Fixer bus write address |
| exec_halt | output | 1 | Halt line to the executor |
| exec_bus_en | output | 1 | Bus-driver enable for the executor |
| fix_halt | output | 1 | Halt line to the fixer |
| fix_bus_en | output | 1 | Bus-driver enable for the fixer |
| latched_addr | output | ADDR_W | Captured faulting address |
| fault_err | output | 1 | Sticky flag for a fault raised outside phase 0 |
| phase | output | 2 | Current phase: 0 running, 1 handing off, 2 fixer, 3 handing back |

## Verification
Two events can land in the same cycle while the fixer owns the bus: a stray fault and the completion write. The bench drives both in one phase-2 cycle. It expects phase 3 on the next edge, a set error flag, and the address from the original fault still latched. A second collision is a completion write in the same cycle as a phase-0 fault. Here the fault must win and the write must be ignored. A reference model in the driver predicts every cycle, and the monitor compares the results.

// File: rtl/fho_pkg.sv
package fho_pkg;

    typedef enum logic [1:0] {
        PH_EXEC    = 2'd0,
        PH_TO_FIX  = 2'd1,
        PH_FIX     = 2'd2,
        PH_TO_EXEC = 2'd3
    } phase_e;

    typedef struct packed {
        logic exec_halt;
        logic exec_bus_en;
        logic fix_halt;
        logic fix_bus_en;
    } bus_ctl_t;

    function automatic bus_ctl_t ctl_for(phase_e ph);
        bus_ctl_t c;
        c.exec_bus_en = (ph == PH_EXEC);
        c.exec_halt   = (ph != PH_EXEC);
        c.fix_bus_en  = (ph == PH_FIX);
        c.fix_halt    = (ph != PH_FIX);
        return c;
    endfunction

endpackage

// File: rtl/fho_done_decode.sv
module fho_done_decode #(
    parameter int unsigned          ADDR_W    = 24,
    parameter logic [ADDR_W-1:0]    CTRL_ADDR = '1
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              done
);
    assign done = wr_en && (wr_addr == CTRL_ADDR);
endmodule

// File: rtl/fho_addr_latch.sv
module fho_addr_latch #(
    parameter int unsigned ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q
);
    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (capture) addr_q <= addr_in;
    end

    // R6: the address holds unless a fault is accepted
    p_addr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(addr_q));
endmodule

// File: rtl/fho_sequencer.sv
module fho_sequencer
    import fho_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   fault,
    input  logic   done,
    output phase_e phase_q,
    output logic   accept,
    output logic   err_q
);
    phase_e phase_d;

    assign accept = fault && (phase_q == PH_EXEC);

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_EXEC:    if (fault) phase_d = PH_TO_FIX;
            PH_TO_FIX:  phase_d = PH_FIX;
            PH_FIX:     if (done)  phase_d = PH_TO_EXEC;
            PH_TO_EXEC: phase_d = PH_EXEC;
            default:    phase_d = PH_EXEC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_EXEC;
            err_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            if (fault && (phase_q != PH_EXEC)) err_q <= 1'b1;
        end
    end

    // R7: error flag is sticky
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        err_q |=> err_q);
    // R7: a fault outside the running phase sets the flag
    p_err_set_r7: assert property (@(posedge clk) disable iff (rst)
        (fault && phase_q != PH_EXEC) |=> err_q);
    // R8: completion outside the fixer phase does not start a hand-back
    p_done_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        (done && phase_q == PH_EXEC && !fault) |=> (phase_q == PH_EXEC));
endmodule

// File: rtl/fault_handoff_ctrl.sv
module fault_handoff_ctrl
    import fho_pkg::*;
#(
    parameter int unsigned       ADDR_W    = 24,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 24'hFF_F000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xlat_fault,
    input  logic [ADDR_W-1:0] fault_addr_in,
    input  logic              fix_wr_en,
    input  logic [ADDR_W-1:0] fix_wr_addr,
    output logic              exec_halt,
    output logic              exec_bus_en,
    output logic              fix_halt,
    output logic              fix_bus_en,
    output logic [ADDR_W-1:0] latched_addr,
    output logic              fault_err,
    output logic [1:0]        phase
);
    logic     done;
    logic     accept;
    phase_e   phase_q;
    bus_ctl_t ctl;

    fho_done_decode #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_dec (
        .wr_en   (fix_wr_en),
        .wr_addr (fix_wr_addr),
        .done    (done)
    );

    fho_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .fault   (xlat_fault),
        .done    (done),
        .phase_q (phase_q),
        .accept  (accept),
        .err_q   (fault_err)
    );

    fho_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .capture (accept),
        .addr_in (fault_addr_in),
        .addr_q  (latched_addr)
    );

    assign ctl         = ctl_for(phase_q);
    assign exec_halt   = ctl.exec_halt;
    assign exec_bus_en = ctl.exec_bus_en;
    assign fix_halt    = ctl.fix_halt;
    assign fix_bus_en  = ctl.fix_bus_en;
    assign phase       = phase_q;

    // R2: a fault while the executor owns the bus freezes it next cycle
    p_fault_freeze_r2: assert property (@(posedge clk) disable iff (rst)
        (xlat_fault && exec_bus_en) |=> (exec_halt && !exec_bus_en && !fix_bus_en));
    // R3: the fixer gets the bus right after the dead cycle
    p_fixer_release_r3: assert property (@(posedge clk) disable iff (rst)
        (exec_halt && fix_halt && phase == 2'd1) |=> (fix_bus_en && !fix_halt && exec_halt));
    // R4: completion hands the bus back through one dead cycle
    p_handback_r4: assert property (@(posedge clk) disable iff (rst)
        (fix_bus_en && done) |=> (!fix_bus_en && !exec_bus_en && fix_halt) ##1 (exec_bus_en && !exec_halt));
    // R5: never both drivers enabled
    p_mutex_r5: assert property (@(posedge clk) disable iff (rst)
        !(exec_bus_en && fix_bus_en));
    // R5: dead cycle before each new owner
    p_dead_fix_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(fix_bus_en) |-> !$past(exec_bus_en));
    p_dead_exec_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(exec_bus_en) |-> !$past(fix_bus_en));
endmodule

// File: tb/fault_handoff_ctrl_test.sv
`timescale 1ns/1ps
module fault_handoff_ctrl_test;
    localparam int unsigned   AW   = 24;
    localparam logic [AW-1:0] CTRL = 24'hFF_F000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          xlat_fault = 1'b0;
    logic [AW-1:0] fault_addr_in = '0;
    logic          fix_wr_en = 1'b0;
    logic [AW-1:0] fix_wr_addr = '0;
    logic          exec_halt, exec_bus_en, fix_halt, fix_bus_en, fault_err;
    logic [AW-1:0] latched_addr;
    logic [1:0]    phase;

    always #10 clk = ~clk;

    fault_handoff_ctrl #(.ADDR_W(AW), .CTRL_ADDR(CTRL)) uut (
        .clk(clk), .rst(rst), .xlat_fault(xlat_fault), .fault_addr_in(fault_addr_in),
        .fix_wr_en(fix_wr_en), .fix_wr_addr(fix_wr_addr),
        .exec_halt(exec_halt), .exec_bus_en(exec_bus_en),
        .fix_halt(fix_halt), .fix_bus_en(fix_bus_en),
        .latched_addr(latched_addr), .fault_err(fault_err), .phase(phase)
    );

    typedef struct {
        logic [1:0]    ph;
        logic          err;
        logic [AW-1:0] addr;
        string         tag;
    } exp_t;

    exp_t q[$];
    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;

    logic [1:0]    m_ph   = 2'd0;
    logic          m_err  = 1'b0;
    logic [AW-1:0] m_addr = '0;

    task automatic compare(input exp_t e);
        logic eh, eb, fh, fb;
        eb = (e.ph == 2'd0); eh = !eb;
        fb = (e.ph == 2'd2); fh = !fb;
        checks++;
        if (phase !== e.ph || fault_err !== e.err || latched_addr !== e.addr ||
            exec_halt !== eh || exec_bus_en !== eb || fix_halt !== fh || fix_bus_en !== fb) begin
            fails++;
            $display("FAIL %s: got ph=%0d err=%0b addr=%h eh=%0b eb=%0b fh=%0b fb=%0b, expected ph=%0d err=%0b addr=%h eh=%0b eb=%0b fh=%0b fb=%0b",
                     e.tag, phase, fault_err, latched_addr, exec_halt, exec_bus_en, fix_halt, fix_bus_en,
                     e.ph, e.err, e.addr, eh, eb, fh, fb);
        end
    endtask

    // driver: applies one cycle of stimulus and predicts the result
    task automatic step(input logic f, input logic [AW-1:0] fa,
                        input logic w, input logic [AW-1:0] wa, input string tag);
        exp_t e;
        logic dn;
        @(negedge clk);
        xlat_fault = f; fault_addr_in = fa; fix_wr_en = w; fix_wr_addr = wa;
        dn = w && (wa == CTRL);
        if (f && m_ph != 2'd0) m_err = 1'b1;
        case (m_ph)
            2'd0: if (f) begin m_ph = 2'd1; m_addr = fa; end
            2'd1: m_ph = 2'd2;
            2'd2: if (dn) m_ph = 2'd3;
            default: m_ph = 2'd0;
        endcase
        e.ph = m_ph; e.err = m_err; e.addr = m_addr; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: compares after every edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (!rst && q.size() > 0) compare(q.pop_front());
        end
    end

    task automatic do_reset(input string tag);
        exp_t e;
        @(negedge clk);
        rst = 1'b1; xlat_fault = 1'b0; fix_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        m_ph = 2'd0; m_err = 1'b0; m_addr = '0;
        e.ph = 2'd0; e.err = 1'b0; e.addr = '0; e.tag = tag;
        compare(e);
        rst = 1'b0;
    endtask

    initial begin
        do_reset("R1 reset state");
        step(0, 24'h0, 0, 24'h0,  "R1 idle after reset");
        step(0, 24'h0, 1, CTRL,   "R8 completion in phase 0 ignored");
        step(0, 24'h0, 1, 24'h12, "R8 stray write in phase 0");
        step(1, 24'h00_1234, 0, 0, "R2 fault freezes executor; R6 capture");
        step(0, 24'h0, 0, 0,       "R3 fixer released");
        step(0, 24'h0, 1, CTRL+1,  "R8 other address in phase 2");
        step(0, 24'h0, 0, 0,       "R6 address held in phase 2");
        step(0, 24'h0, 1, CTRL,    "R4 completion to handing back");
        step(0, 24'h0, 0, 0,       "R4 executor released; R5 dead cycle");
        step(0, 24'h0, 0, 0,       "R6 address held after return");
        step(1, 24'h0A_BCDE, 1, CTRL, "R8 fault beats completion in phase 0");
        step(1, 24'h33_3333, 0, 0,    "R7 fault in phase 1");
        step(1, 24'h44_4444, 0, 0,    "R7 fault in phase 2 keeps owner");
        step(1, 24'h55_5555, 1, CTRL, "R9 fault and completion together");
        step(1, 24'h66_6666, 0, 0,    "R7 fault in phase 3");
        step(0, 24'h0, 0, 0,          "R7 flag sticky in phase 0");
        step(1, 24'h77_0001, 0, 0,    "R6 new capture with flag set");
        step(0, 24'h0, 1, CTRL,       "R8 completion in phase 1 ignored");
        step(0, 24'h0, 0, 0,          "R8 still fixer after early write");
        step(0, 24'h0, 1, CTRL,       "R4 completion");
        step(0, 24'h0, 0, 0,          "R5 back to executor");
        @(negedge clk);
        @(negedge clk);
        do_reset("R1 reset clears flag and address");
        step(0, 24'h0, 0, 0, "R1 idle after second reset");
        @(negedge clk);
        @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule